// File: doc/BRIEF.md
# Pipelined Half-Precision Multiply-Accumulate

This block computes `a*b + c` on 16-bit binary floating-point operands. The addend `c` is supplied by the caller on a third input, so the block can serve as the arithmetic core of an accumulation loop or a dot-product engine. It has no feedback path of its own.

The arithmetic runs through six registered stages. The first three form the product: unpack and multiply significands, then combine exponents, then normalize the product. The last three form the sum: align the two addends, then add or subtract magnitudes, then renormalize and round. The full-width product goes into the adder without rounding. Guard, round and sticky information is carried through alignment. A fresh operand triple may enter on every clock. Each result leaves exactly six clocks later, and a valid flag travels with it.

Results that are too large saturate to a signed infinity. Results that are too small flush to a signed zero. Zero and subnormal operands are treated as zero. Exception flags and stalls are not provided.

Top module: `hmac_pipe`

## Requirements
- R1: Operands and results use this encoding: bit 15 is the sign, bits 14:10 are a biased exponent (bias 15), and bits 9:0 are a fraction with a hidden leading 1. When `a*b+c` is representable, it is returned exactly (e.g. 0xC100 × 0xC740 + 0 = 0x4C88).
- R2: A result with `out_valid` high appears exactly six clock edges after the edge that captured its `in_valid` operands. `out_valid` stays low when no operation was captured six edges earlier.
- R3: Operand triples may be presented on consecutive clocks, or with idle gaps, and each one produces its own result in issue order.
- R4: When the product and addend have opposite signs, the smaller magnitude is subtracted from the larger and the sign of the larger is kept.
- R5: An exact cancellation produces +0 (0x0000).
- R6: Inexact results are rounded to nearest, with ties going to an even fraction.
- R7: When rounding carries out of the fraction, the exponent increments and the fraction becomes 0 (e.g. 1 × 0x3BFF + 0x0C00 = 0x3C00).
- R8: A rounded exponent above 30 yields a signed infinity: exponent field 31 and fraction 0 (0x7C00 or 0xFC00).
- R9: A rounded exponent below 1 yields a zero that keeps the sign of the result (0x0000 or 0x8000).
- R10: An operand whose exponent field is 0 is treated as zero. A zero product returns `c` unchanged.
- R11: Synchronous reset clears every in-flight operation. `out_valid` is low in the cycle after reset, and nothing issued before reset emerges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand triple on `op_a`, `op_b`, `op_c` is valid |
| op_a | input | 16 | Multiplicand |
| op_b | input | 16 | Multiplier |
| op_c | input | 16 | Addend (accumulator value) |
| out_valid | output | 1 | `result` is valid |
| result | output | 16 | Rounded `op_a*op_b+op_c` |

## Verification
Exactly representable products and sums, with the addend either smaller or larger than the product, confirm the unpack, exponent and alignment paths (R1). Opposite-sign pairs separate "keep the product sign" from "keep the addend sign" and expose exact cancellation (R4, R5). Three additions sit near one fraction LSB: an exact tie with an even LSB, an exact tie with an odd LSB, and a value just above a tie. Together they distinguish round-to-nearest-even from truncation and from round-half-up, and a case with all fraction bits set forces the rounding carry (R6, R7). Over- and underflow products of both signs, zero and subnormal multiplicands, back-to-back and gapped issue, and a reset with operations in flight cover saturation, flushing, throughput, latency and flush-on-reset.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
    localparam int EXP_W   = 5;
    localparam int FRAC_W  = 10;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int GRS_W   = 3;
    localparam int ALN_W   = PROD_W + GRS_W;
    localparam int SE_W    = 10;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 2;
    localparam int LZ_W    = $clog2(ALN_W + 1);

    typedef logic signed [SE_W-1:0] sexp_t;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        logic             zero;
    } unpk_t;

    typedef struct packed {
        logic              sa;
        logic              sb;
        logic [EXP_W-1:0]  ea;
        logic [EXP_W-1:0]  eb;
        logic [PROD_W-1:0] prod;
        logic              pz;
        unpk_t             c;
    } mul_rec_t;

    typedef struct packed {
        logic              sgn;
        sexp_t             e;
        logic [PROD_W-1:0] prod;
        logic              pz;
        unpk_t             c;
    } prd_rec_t;

    typedef struct packed {
        logic             s_big;
        logic             s_small;
        sexp_t            e;
        logic [ALN_W-1:0] m_big;
        logic [ALN_W-1:0] m_small;
        logic             zero;
    } aln_rec_t;

    typedef struct packed {
        logic           sgn;
        sexp_t          e;
        logic [ALN_W:0] mag;
        logic           zero;
    } sum_rec_t;

    function automatic unpk_t unpack(logic [WORD_W-1:0] w);
        unpk_t u;
        u.sgn  = w[WORD_W-1];
        u.exp  = w[WORD_W-2 -: EXP_W];
        u.sig  = {1'b1, w[FRAC_W-1:0]};
        u.zero = (u.exp == '0);
        return u;
    endfunction

    function automatic logic [ALN_W-1:0] sticky_shr(logic [ALN_W-1:0] m, logic [LZ_W:0] d);
        logic [ALN_W-1:0] mask;
        if (d >= (LZ_W+1)'(ALN_W)) return {{(ALN_W-1){1'b0}}, |m};
        mask = ~({ALN_W{1'b1}} << d);
        return (m >> d) | {{(ALN_W-1){1'b0}}, |(m & mask)};
    endfunction
endpackage

// File: rtl/hmac_mul_stages.sv
module hmac_mul_stages
    import hmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [WORD_W-1:0] c_i,
    output logic              vld_o,
    output prd_rec_t          rec_o
);
    mul_rec_t s1;
    prd_rec_t s2, s3;
    logic     v1, v2, v3;
    unpk_t    ua, ub;

    assign ua = unpack(a_i);
    assign ub = unpack(b_i);

    // stage 1: unpack and multiply significands
    always_ff @(posedge clk) begin
        v1      <= rst ? 1'b0 : vld_i;
        s1.sa   <= ua.sgn;
        s1.sb   <= ub.sgn;
        s1.ea   <= ua.exp;
        s1.eb   <= ub.exp;
        s1.prod <= ua.sig * ub.sig;
        s1.pz   <= ua.zero | ub.zero;
        s1.c    <= unpack(c_i);
    end

    // stage 2: exponent sum minus one bias, product sign
    always_ff @(posedge clk) begin
        v2      <= rst ? 1'b0 : v1;
        s2.sgn  <= s1.sa ^ s1.sb;
        s2.e    <= sexp_t'({5'b0, s1.ea}) + sexp_t'({5'b0, s1.eb}) - sexp_t'(BIAS);
        s2.prod <= s1.prod;
        s2.pz   <= s1.pz;
        s2.c    <= s1.c;
    end

    // stage 3: bring the product's leading one to the top bit
    always_ff @(posedge clk) begin
        v3     <= rst ? 1'b0 : v2;
        s3.sgn <= s2.sgn;
        s3.pz  <= s2.pz;
        s3.c   <= s2.c;
        if (s2.prod[PROD_W-1]) begin
            s3.e    <= s2.e + sexp_t'(1);
            s3.prod <= s2.prod;
        end else begin
            s3.e    <= s2.e;
            s3.prod <= s2.prod << 1;
        end
    end

    assign vld_o = v3;
    assign rec_o = s3;
endmodule

// File: rtl/hmac_add_stages.sv
module hmac_add_stages
    import hmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     vld_i,
    input  prd_rec_t rec_i,
    output logic     vld_o,
    output sum_rec_t rec_o
);
    aln_rec_t         s4, a4;
    sum_rec_t         s5, a5;
    logic             v4, v5;
    logic [ALN_W-1:0] pm, cm;
    sexp_t            pe, ce, diff;
    logic [LZ_W:0]    dsh;

    // stage 4: choose the operand with the larger exponent, align the other
    always_comb begin
        pe   = rec_i.e;
        ce   = sexp_t'({5'b0, rec_i.c.exp});
        pm   = {rec_i.prod, {GRS_W{1'b0}}};
        cm   = {rec_i.c.sig, {(PROD_W-SIG_W){1'b0}}, {GRS_W{1'b0}}};
        diff = (pe >= ce) ? (pe - ce) : (ce - pe);
        dsh  = (diff > sexp_t'(ALN_W)) ? (LZ_W+1)'(ALN_W) : diff[LZ_W:0];
        a4.zero = rec_i.pz & rec_i.c.zero;
        if (rec_i.pz) begin
            a4.s_big = rec_i.c.sgn; a4.e = ce; a4.m_big = cm;
            a4.s_small = rec_i.sgn; a4.m_small = '0;
        end else if (rec_i.c.zero) begin
            a4.s_big = rec_i.sgn; a4.e = pe; a4.m_big = pm;
            a4.s_small = rec_i.c.sgn; a4.m_small = '0;
        end else if (pe >= ce) begin
            a4.s_big = rec_i.sgn; a4.e = pe; a4.m_big = pm;
            a4.s_small = rec_i.c.sgn; a4.m_small = sticky_shr(cm, dsh);
        end else begin
            a4.s_big = rec_i.c.sgn; a4.e = ce; a4.m_big = cm;
            a4.s_small = rec_i.sgn; a4.m_small = sticky_shr(pm, dsh);
        end
    end

    // stage 5: signed-magnitude add or subtract
    always_comb begin
        a5.e = s4.e;
        if (s4.s_big == s4.s_small) begin
            a5.mag = {1'b0, s4.m_big} + {1'b0, s4.m_small};
            a5.sgn = s4.s_big;
        end else if (s4.m_big >= s4.m_small) begin
            a5.mag = {1'b0, s4.m_big} - {1'b0, s4.m_small};
            a5.sgn = s4.s_big;
        end else begin
            a5.mag = {1'b0, s4.m_small} - {1'b0, s4.m_big};
            a5.sgn = s4.s_small;
        end
        a5.zero = s4.zero | (a5.mag == '0);
        if (a5.zero) a5.sgn = 1'b0;
    end

    always_ff @(posedge clk) begin
        v4 <= rst ? 1'b0 : vld_i;
        v5 <= rst ? 1'b0 : v4;
        s4 <= a4;
        s5 <= a5;
    end

    assign vld_o = v5;
    assign rec_o = s5;
endmodule

// File: rtl/hmac_round_stage.sv
module hmac_round_stage
    import hmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  sum_rec_t          rec_i,
    output logic              vld_o,
    output logic [WORD_W-1:0] res_o
);
    logic [LZ_W-1:0]   lz;
    logic [ALN_W:0]    norm;
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   rsum;
    logic              guard, sticky, up, is_zero;
    sexp_t             e2, e3;
    logic [WORD_W-1:0] res_d;

    always_comb begin
        lz = '0;
        for (int i = 0; i <= ALN_W; i++)
            if (rec_i.mag[i]) lz = LZ_W'(ALN_W - i);
        norm    = rec_i.mag << lz;
        is_zero = rec_i.zero | ~norm[ALN_W];
        e2      = rec_i.e + sexp_t'(1) - sexp_t'({{(SE_W-LZ_W){1'b0}}, lz});
        frac    = norm[ALN_W-1 -: FRAC_W];
        guard   = norm[ALN_W-1-FRAC_W];
        sticky  = |norm[ALN_W-2-FRAC_W:0];
        up      = guard & (sticky | frac[0]);
        rsum    = {1'b0, frac} + (FRAC_W+1)'(up);
        e3      = rsum[FRAC_W] ? e2 + sexp_t'(1) : e2;
        if (is_zero)
            res_d = '0;
        else if (e3 > sexp_t'(EXP_TOP))
            res_d = {rec_i.sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (e3 < sexp_t'(1))
            res_d = {rec_i.sgn, {(WORD_W-1){1'b0}}};
        else
            res_d = {rec_i.sgn, e3[EXP_W-1:0], rsum[FRAC_W-1:0]};
    end

    always_ff @(posedge clk) begin
        vld_o <= rst ? 1'b0 : vld_i;
        res_o <= res_d;
    end
endmodule

// File: rtl/hmac_pipe.sv
module hmac_pipe
    import hmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] op_a,
    input  logic [15:0] op_b,
    input  logic [15:0] op_c,
    output logic        out_valid,
    output logic [15:0] result
);
    logic     v_prd, v_sum;
    prd_rec_t prd;
    sum_rec_t sum;

    hmac_mul_stages u_mul (
        .clk(clk), .rst(rst), .vld_i(in_valid),
        .a_i(op_a), .b_i(op_b), .c_i(op_c),
        .vld_o(v_prd), .rec_o(prd)
    );

    hmac_add_stages u_add (
        .clk(clk), .rst(rst), .vld_i(v_prd), .rec_i(prd),
        .vld_o(v_sum), .rec_o(sum)
    );

    hmac_round_stage u_rnd (
        .clk(clk), .rst(rst), .vld_i(v_sum), .rec_i(sum),
        .vld_o(out_valid), .res_o(result)
    );
endmodule

// File: rtl/hmac_pipe_chk.sv
module hmac_pipe_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        out_valid,
    input logic [15:0] result
);
    logic [2:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##6 out_valid);

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd6 && !$past(in_valid, 6)) |-> !out_valid);

    p_inf_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[14:10] == 5'h1F) |-> result[9:0] == 10'd0);

    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && result[14:10] == 5'h00) |-> result[9:0] == 10'd0);

    p_reset_r11: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind hmac_pipe hmac_pipe_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .out_valid(out_valid), .result(result)
);

// File: tb/hmac_pipe_test.sv
`timescale 1ns/1ps
module hmac_pipe_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0, op_b = '0, op_c = '0;
    logic        out_valid;
    logic [15:0] result;

    typedef struct {
        logic [15:0] exp;
        int          issue;
        string       req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;

    hmac_pipe uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .out_valid(out_valid), .result(result)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic send(logic [15:0] a, logic [15:0] b, logic [15:0] c,
                        logic [15:0] e, string req);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; in_valid = 1'b1;
        it.exp = e; it.issue = cyc; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compare each valid result against the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected out_valid", 1, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                check(result == it.exp, it.req, "result", result, it.exp);
                check(cyc - it.issue == 6, "R2", "latency", cyc - it.issue, 6);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            check(1'b0, "R2", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11", "out_valid during reset", out_valid, 0);
        rst = 1'b0;

        // back-to-back issue (R3)
        send(16'h3400, 16'h3C00, 16'h3A00, 16'h3C00, "R1");
        send(16'hC100, 16'hC740, 16'h0000, 16'h4C88, "R1");
        send(16'hC020, 16'hC740, 16'h0000, 16'h4B7A, "R1");
        send(16'h3C00, 16'h3C00, 16'hBA00, 16'h3400, "R4");
        send(16'h3400, 16'h3C00, 16'hBA00, 16'hB800, "R4");
        send(16'h3C00, 16'h3C00, 16'hBC00, 16'h0000, "R5");
        send(16'hBC00, 16'h3C00, 16'h3C00, 16'h0000, "R5");
        send(16'h3C00, 16'h3C00, 16'h1000, 16'h3C00, "R6");
        send(16'h3C01, 16'h3C00, 16'h1000, 16'h3C02, "R6");
        send(16'h3C00, 16'h3C00, 16'h1001, 16'h3C01, "R6");
        send(16'h3C00, 16'h3BFF, 16'h0C00, 16'h3C00, "R7");
        send(16'h7BFF, 16'h4000, 16'h0000, 16'h7C00, "R8");
        send(16'hFBFF, 16'h4000, 16'h0000, 16'hFC00, "R8");
        send(16'h0400, 16'h3800, 16'h0000, 16'h0000, "R9");
        send(16'h8400, 16'h3800, 16'h0000, 16'h8000, "R9");
        send(16'h0000, 16'h4000, 16'h4200, 16'h4200, "R10");
        send(16'h0001, 16'h4000, 16'hC200, 16'hC200, "R10");
        idle(10);

        // gapped issue (R3)
        send(16'hC100, 16'hC740, 16'h0000, 16'h4C88, "R3");
        idle(2);
        send(16'h3C00, 16'h3C00, 16'hBA00, 16'h3400, "R3");
        idle(1);
        send(16'h3C00, 16'h3BFF, 16'h0C00, 16'h3C00, "R3");
        idle(10);

        // reset with operations in flight (R11)
        send(16'h3C00, 16'h3C00, 16'h0000, 16'h3C00, "R11");
        send(16'h4000, 16'h4000, 16'h0000, 16'h4400, "R11");
        send(16'h3800, 16'h3C00, 16'h0000, 16'h3800, "R11");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        q.delete();
        @(negedge clk);
        check(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);
        rst = 1'b0;
        idle(10);

        // pipeline still works after reset (R2)
        send(16'h3400, 16'h3C00, 16'hBA00, 16'hB800, "R2");
        idle(10);

        check(q.size() == 0, "R3", "results outstanding", q.size(), 0);
        done = 1'b1;
        finish_run();
    end
endmodule